// File: doc/BRIEF.md
# Multicore Run-Control Status Unit

This block gives a host run control over four processor cores through a memory-mapped slave port with a one-bit address. For each core it drives a halt request and a single-step pulse. It also watches two lines coming back from that core: a breakpoint flag and a halted acknowledge. A 32-bit status word at address 0 packs the registered state of each core into that core's own byte.

After reset, core 0 is allowed to run and the other three cores are held halted. A host write to address 0 sets the halt request of every core at once. The same write can ask a halted core to advance by one step.

A core may acknowledge a halt or a step after any number of cycles. The unit never assumes a fixed delay. It reports the halted state the core actually acknowledges, one register stage after the core presents it.

Top module: `rc_run_control`

## Requirements
- R1: While reset is low (asynchronous, active-low), the halt outputs are 4'b1110, so core 0 runs and cores 1 to 3 are halted. The step outputs read 0 and the read data reads 0.
- R2: A read of address 0 places the status word on the read data one cycle after the read strobe. Byte n (bits 8n+7:8n) holds core n: bit 8n is halted, bit 8n+1 is breakpoint, and the remaining bits of the byte are 0.
- R3: Status bit 8n equals the core's halted input as sampled at the previous clock edge. Once the secondary cores acknowledge the boot halt, address 0 reads 32'h0101_0100.
- R4: A write to address 0 loads bit 8n+2 of the write data into core n's halt output. The new value appears in the cycle after the write.
- R5: A write to address 0 with bit 8n+3 set, while core n's status halted bit is 1, gives exactly one cycle of step output for core n. The step output never stays high for two cycles in a row.
- R6: A step request for a core whose status halted bit is 0 produces no step pulse.
- R7: The breakpoint status bit is sticky. It becomes 1 in the cycle after the core's breakpoint input is sampled high, and it stays 1 through writes that keep the core halted.
- R8: A write to address 0 with bit 8n+2 clear (resume) clears core n's breakpoint bit. If the breakpoint input is high in the same cycle, the bit stays 1.
- R9: A write to address 1 changes no halt, step or breakpoint state. A read of address 1 returns 0.
- R10: The read data holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| avs_address | input | 1 | Word address; only 0 is decoded |
| avs_read | input | 1 | Read strobe |
| avs_write | input | 1 | Write strobe |
| avs_writedata | input | 32 | Write data: bit 8n+2 is the halt request of core n, bit 8n+3 its step request |
| avs_readdata | output | 32 | Read data, valid one cycle after the read strobe |
| core_halt_o | output | 4 | Halt request, one bit per core |
| core_step_o | output | 4 | Single-cycle step pulse, one bit per core |
| core_bkpt_i | input | 4 | Breakpoint flag from each core |
| core_halted_i | input | 4 | Halted acknowledge from each core |

## Verification
A wrong halt register shows up on the halt outputs in the cycle right after the write. A step gate that wrongly opens or stays shut shows up as an extra or missing step pulse in that same cycle. A breakpoint latch that is lost or never cleared stays hidden until the next status read, and then it appears one cycle after the read strobe in bit 8n+1. The core models acknowledge with a different delay per core, from 0 to 10 cycles. This exposes any wrong sampling of the halted acknowledge in the status bits within one read.

// File: rtl/rc_pkg.sv
package rc_pkg;
   // Bit positions inside one core's byte lane. Status and control share the lane.
   localparam int LANE_HALTED_BIT   = 0;
   localparam int LANE_BKPT_BIT     = 1;
   localparam int LANE_HALT_REQ_BIT = 2;
   localparam int LANE_STEP_REQ_BIT = 3;
   localparam int LANE_MIN_W        = 4;

   typedef struct packed {
      logic bkpt;
      logic halted;
   } lane_stat_t;

   localparam int LANE_STAT_W = $bits(lane_stat_t);
endpackage

// File: rtl/rc_host_if.sv
module rc_host_if #(
   parameter int ADDR_W = 1
) (
   input  logic [ADDR_W-1:0] avs_address,
   input  logic              avs_read,
   input  logic              avs_write,
   output logic              wr_hit,
   output logic              rd_hit,
   output logic              rd_miss
);
   logic addr_zero;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("rc_host_if: ADDR_W must be at least 1");
      end
   endgenerate

   // Only word 0 is decoded. Every other address is accepted and ignored.
   always_comb begin
      addr_zero = (avs_address == '0);
      wr_hit    = avs_write && addr_zero;
      rd_hit    = avs_read && addr_zero;
      rd_miss   = avs_read && !addr_zero;
   end
endmodule

// File: rtl/rc_core_lane.sv
module rc_core_lane
   import rc_pkg::*;
#(
   parameter int LANE_W      = 8,
   parameter bit BOOT_HALTED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [LANE_W-1:0] lane_wdata,
   input  logic              bkpt_in,
   input  logic              halted_in,
   output logic              halt_out,
   output logic              step_out,
   output lane_stat_t        stat
);
   logic halt_q;
   logic step_q;
   logic bkpt_q;
   logic halted_q;
   logic want_halt;
   logic want_step;
   logic resume_wr;
   logic step_fire;

   generate
      if (LANE_W < LANE_MIN_W) begin : g_bad_lane
         $error("rc_core_lane: LANE_W too small for control bits");
      end
   endgenerate

   always_comb begin
      want_halt = lane_wdata[LANE_HALT_REQ_BIT];
      want_step = lane_wdata[LANE_STEP_REQ_BIT];
      resume_wr = wr_hit && !want_halt;
      // A step needs the acknowledged halt state and never stretches past one cycle.
      step_fire = wr_hit && want_step && halted_q && !step_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= BOOT_HALTED;
      end else if (wr_hit) begin
         halt_q <= want_halt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= 1'b0;
      end else begin
         step_q <= step_fire;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
      end else begin
         halted_q <= halted_in;
      end
   end

   // A new breakpoint wins over a clearing resume in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bkpt_q <= 1'b0;
      end else if (bkpt_in) begin
         bkpt_q <= 1'b1;
      end else if (resume_wr) begin
         bkpt_q <= 1'b0;
      end
   end

   always_comb begin
      halt_out    = halt_q;
      step_out    = step_q;
      stat.halted = halted_q;
      stat.bkpt   = bkpt_q;
   end
endmodule

// File: rtl/rc_status_port.sv
module rc_status_port
   import rc_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int LANE_W    = 8,
   localparam int DATA_W   = NUM_CORES * LANE_W,
   localparam int PAD_W    = LANE_W - LANE_STAT_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_hit,
   input  logic                         rd_miss,
   input  lane_stat_t [NUM_CORES-1:0]   stat_in,
   output logic [DATA_W-1:0]            status_word,
   output logic [DATA_W-1:0]            rdata
);
   logic [DATA_W-1:0] rdata_q;

   generate
      for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_pack
         assign status_word[gi*LANE_W + LANE_HALTED_BIT] = stat_in[gi].halted;
         assign status_word[gi*LANE_W + LANE_BKPT_BIT]   = stat_in[gi].bkpt;
         if (PAD_W > 0) begin : g_pad
            assign status_word[gi*LANE_W + LANE_STAT_W +: PAD_W] = '0;
         end
      end
   endgenerate

   // Fixed one-cycle read latency. The data holds until the next read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_hit) begin
         rdata_q <= status_word;
      end else if (rd_miss) begin
         rdata_q <= '0;
      end
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/rc_run_control.sv
module rc_run_control
   import rc_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int LANE_W    = 8,
   parameter int ADDR_W    = 1,
   parameter logic [NUM_CORES-1:0] BOOT_HALT = {{(NUM_CORES-1){1'b1}}, 1'b0},
   localparam int DATA_W   = NUM_CORES * LANE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    avs_address,
   input  logic                 avs_read,
   input  logic                 avs_write,
   input  logic [DATA_W-1:0]    avs_writedata,
   output logic [DATA_W-1:0]    avs_readdata,
   output logic [NUM_CORES-1:0] core_halt_o,
   output logic [NUM_CORES-1:0] core_step_o,
   input  logic [NUM_CORES-1:0] core_bkpt_i,
   input  logic [NUM_CORES-1:0] core_halted_i
);
   logic                       wr_hit;
   logic                       rd_hit;
   logic                       rd_miss;
   lane_stat_t [NUM_CORES-1:0] lane_stat;
   logic [DATA_W-1:0]          status_word;

   generate
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("rc_run_control: NUM_CORES must be at least 1");
      end
      if (LANE_W < LANE_MIN_W) begin : g_bad_lane
         $error("rc_run_control: LANE_W must hold the control bits");
      end
   endgenerate

   rc_host_if #(.ADDR_W(ADDR_W)) u_host (
      .avs_address (avs_address),
      .avs_read    (avs_read),
      .avs_write   (avs_write),
      .wr_hit      (wr_hit),
      .rd_hit      (rd_hit),
      .rd_miss     (rd_miss)
   );

   generate
      for (genvar gc = 0; gc < NUM_CORES; gc++) begin : g_lane
         rc_core_lane #(
            .LANE_W      (LANE_W),
            .BOOT_HALTED (BOOT_HALT[gc])
         ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_hit     (wr_hit),
            .lane_wdata (avs_writedata[gc*LANE_W +: LANE_W]),
            .bkpt_in    (core_bkpt_i[gc]),
            .halted_in  (core_halted_i[gc]),
            .halt_out   (core_halt_o[gc]),
            .step_out   (core_step_o[gc]),
            .stat       (lane_stat[gc])
         );
      end
   endgenerate

   rc_status_port #(
      .NUM_CORES (NUM_CORES),
      .LANE_W    (LANE_W)
   ) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_hit      (rd_hit),
      .rd_miss     (rd_miss),
      .stat_in     (lane_stat),
      .status_word (status_word),
      .rdata       (avs_readdata)
   );
endmodule

// File: rtl/rc_run_control_chk.sv
module rc_run_control_chk #(
   parameter int NUM_CORES = 4,
   parameter int LANE_W    = 8,
   parameter int ADDR_W    = 1,
   localparam int DATA_W   = NUM_CORES * LANE_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    avs_address,
   input logic                 avs_read,
   input logic                 avs_write,
   input logic [DATA_W-1:0]    avs_writedata,
   input logic [DATA_W-1:0]    avs_readdata,
   input logic [NUM_CORES-1:0] core_halt_o,
   input logic [NUM_CORES-1:0] core_step_o,
   input logic [NUM_CORES-1:0] core_bkpt_i,
   input logic [DATA_W-1:0]    status_word
);
   logic wr0;
   logic wr1;
   assign wr0 = avs_write && (avs_address == '0);
   assign wr1 = avs_write && (avs_address != '0);

   // R10: read data only moves on a read strobe
   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !avs_read |=> $stable(avs_readdata));

   // R9: reads of the undecoded word return zero
   assert_rd_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (avs_read && avs_address != '0) |=> avs_readdata == '0);

   // R9: writes to the undecoded word leave halt outputs alone
   assert_wr_miss_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr1 |=> $stable(core_halt_o));

   // R2: a read of word 0 returns the status word
   assert_read_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (avs_read && avs_address == '0) |=> avs_readdata == $past(status_word));

   generate
      for (genvar gc = 0; gc < NUM_CORES; gc++) begin : g_core
         // R4: halt output follows the written halt bit
         assert_halt_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wr0 |=> core_halt_o[gc] == $past(avs_writedata[gc*LANE_W + 2]));

         // R5: step lasts exactly one cycle
         assert_step_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
            core_step_o[gc] |=> !core_step_o[gc]);

         // R5: step only follows a step request on word 0
         assert_step_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_step_o[gc]) |-> $past(wr0 && avs_writedata[gc*LANE_W + 3]));

         // R6: no step while the status shows the core running
         assert_step_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !status_word[gc*LANE_W] |=> !core_step_o[gc]);

         // R7: breakpoint input latches into status
         assert_bkpt_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            core_bkpt_i[gc] |=> status_word[gc*LANE_W + 1]);

         // R7: breakpoint stays set until a resume
         assert_bkpt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (status_word[gc*LANE_W + 1] && !(wr0 && !avs_writedata[gc*LANE_W + 2]))
            |=> status_word[gc*LANE_W + 1]);

         // R8: a resume with no new breakpoint clears the flag
         assert_bkpt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr0 && !avs_writedata[gc*LANE_W + 2] && !core_bkpt_i[gc])
            |=> !status_word[gc*LANE_W + 1]);

         // R2: unused status bits read zero
         assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            status_word[gc*LANE_W + 2 +: LANE_W-2] == '0);
      end
   endgenerate
endmodule

bind rc_run_control rc_run_control_chk #(
   .NUM_CORES (NUM_CORES),
   .LANE_W    (LANE_W),
   .ADDR_W    (ADDR_W)
) u_rc_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .avs_address   (avs_address),
   .avs_read      (avs_read),
   .avs_write     (avs_write),
   .avs_writedata (avs_writedata),
   .avs_readdata  (avs_readdata),
   .core_halt_o   (core_halt_o),
   .core_step_o   (core_step_o),
   .core_bkpt_i   (core_bkpt_i),
   .status_word   (status_word)
);

// File: tb/tb_rc_run_control.sv
`timescale 1ns/1ps
module tb_rc_run_control;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [0:0]  avs_address = '0;
   logic        avs_read = 1'b0;
   logic        avs_write = 1'b0;
   logic [31:0] avs_writedata = '0;
   logic [31:0] avs_readdata;
   logic [3:0]  core_halt_o;
   logic [3:0]  core_step_o;
   logic [3:0]  core_bkpt_i = '0;
   logic [3:0]  core_halted_i;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rc_run_control dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .avs_address   (avs_address),
      .avs_read      (avs_read),
      .avs_write     (avs_write),
      .avs_writedata (avs_writedata),
      .avs_readdata  (avs_readdata),
      .core_halt_o   (core_halt_o),
      .core_step_o   (core_step_o),
      .core_bkpt_i   (core_bkpt_i),
      .core_halted_i (core_halted_i)
   );

   // Core models: acknowledge halt after a per-core delay; a step briefly drops halted.
   int ack_delay [4] = '{0, 3, 7, 10};
   int busy [4];
   int waitc [4];
   logic [3:0] halted_r;
   assign core_halted_i = halted_r;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_r <= '0;
         for (int n = 0; n < 4; n++) begin busy[n] <= 0; waitc[n] <= 0; end
      end else begin
         for (int n = 0; n < 4; n++) begin
            if (core_step_o[n] && halted_r[n]) begin
               halted_r[n] <= 1'b0;
               busy[n] <= 2;
            end else if (busy[n] > 0) begin
               busy[n] <= busy[n] - 1;
               if (busy[n] == 1) halted_r[n] <= core_halt_o[n];
            end else if (halted_r[n] != core_halt_o[n]) begin
               if (waitc[n] >= ack_delay[n]) begin
                  halted_r[n] <= core_halt_o[n];
                  waitc[n] <= 0;
               end else begin
                  waitc[n] <= waitc[n] + 1;
               end
            end else begin
               waitc[n] <= 0;
            end
         end
      end
   end

   // Behavioural reference model, advanced on every clock edge.
   logic [3:0]  m_halt, m_step, m_bkpt, m_hq;
   logic [31:0] m_rd;

   function automatic logic [31:0] pack(input logic [3:0] hq, input logic [3:0] bk);
      logic [31:0] w = '0;
      for (int n = 0; n < 4; n++) begin
         w[8*n]   = hq[n];
         w[8*n+1] = bk[n];
      end
      return w;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_halt = 4'b1110; m_step = '0; m_bkpt = '0; m_hq = '0; m_rd = '0;
      end else begin
         logic wr0;
         logic [3:0] nstep;
         wr0 = avs_write && (avs_address == 1'b0);
         if (avs_read) m_rd = (avs_address == 1'b0) ? pack(m_hq, m_bkpt) : 32'h0;
         for (int n = 0; n < 4; n++) begin
            nstep[n] = wr0 && avs_writedata[8*n+3] && m_hq[n] && !m_step[n];
            if (core_bkpt_i[n]) m_bkpt[n] = 1'b1;
            else if (wr0 && !avs_writedata[8*n+2]) m_bkpt[n] = 1'b0;
            if (wr0) m_halt[n] = avs_writedata[8*n+2];
         end
         m_step = nstep;
         m_hq = core_halted_i;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4", "model halt", {28'h0, core_halt_o}, {28'h0, m_halt});
         chk("R5", "model step", {28'h0, core_step_o}, {28'h0, m_step});
         chk("R2", "model readdata", avs_readdata, m_rd);
      end
   end

   function automatic logic [31:0] wd(input logic [3:0] h, input logic [3:0] s);
      logic [31:0] w = '0;
      for (int n = 0; n < 4; n++) begin
         w[8*n+2] = h[n];
         w[8*n+3] = s[n];
      end
      return w;
   endfunction

   task automatic do_write(input logic a, input logic [31:0] d);
      @(negedge clk);
      avs_address = a; avs_writedata = d; avs_write = 1'b1;
      @(negedge clk);
      avs_write = 1'b0; avs_writedata = '0; avs_address = '0;
   endtask

   task automatic do_read(input logic a, output logic [31:0] v);
      @(negedge clk);
      avs_address = a; avs_read = 1'b1;
      @(negedge clk);
      avs_read = 1'b0; avs_address = '0;
      v = avs_readdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v, held;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "reset halt", {28'h0, core_halt_o}, 32'he);
      chk("R1", "reset step", {28'h0, core_step_o}, 32'h0);
      chk("R1", "reset readdata", avs_readdata, 32'h0);
      rst_n = 1'b1;
      idle(20);

      // R3, R2: boot pattern after acknowledges
      do_read(1'b0, v);
      chk("R3", "boot status", v, 32'h0101_0100);

      // R5: step halted core 1
      do_write(1'b0, wd(4'b1110, 4'b0010));
      chk("R5", "step pulse core1", {28'h0, core_step_o}, 32'h2);
      @(negedge clk);
      chk("R5", "step self-clear core1", {28'h0, core_step_o}, 32'h0);
      idle(5);

      // R6: step request for running core 0
      do_write(1'b0, wd(4'b1110, 4'b0001));
      chk("R6", "no step running core0", {28'h0, core_step_o}, 32'h0);
      idle(2);

      // R4: halt core 0
      do_write(1'b0, wd(4'b1111, 4'b0000));
      chk("R4", "halt all", {28'h0, core_halt_o}, 32'hf);
      idle(15);
      do_read(1'b0, v);
      chk("R3", "all halted", v, 32'h0101_0101);

      // R7: breakpoint latch on core 2
      @(negedge clk); core_bkpt_i[2] = 1'b1;
      @(negedge clk); core_bkpt_i[2] = 1'b0;
      idle(1);
      do_read(1'b0, v);
      chk("R7", "bkpt latched", v, 32'h0103_0101);
      do_write(1'b0, wd(4'b1111, 4'b0000));
      do_read(1'b0, v);
      chk("R7", "bkpt kept on halt write", v, 32'h0103_0101);

      // R10: read data holds between reads
      held = avs_readdata;
      idle(5);
      chk("R10", "readdata held", avs_readdata, held);

      // R8: resume clears
      do_write(1'b0, wd(4'b1011, 4'b0000));
      do_read(1'b0, v);
      chk("R8", "bkpt cleared by resume", {31'h0, v[17]}, 32'h0);

      // R8: new breakpoint beats the clear
      @(negedge clk);
      core_bkpt_i[2] = 1'b1;
      avs_address = 1'b0; avs_writedata = wd(4'b1011, 4'b0000); avs_write = 1'b1;
      @(negedge clk);
      core_bkpt_i[2] = 1'b0; avs_write = 1'b0; avs_writedata = '0;
      do_read(1'b0, v);
      chk("R8", "bkpt set wins over resume", {31'h0, v[17]}, 32'h1);

      // R9: address 1 ignored
      do_write(1'b1, 32'h0000_0000);
      chk("R9", "halt unchanged by addr1 write", {28'h0, core_halt_o}, 32'hb);
      do_read(1'b0, v);
      chk("R9", "bkpt unchanged by addr1 write", {31'h0, v[17]}, 32'h1);
      do_read(1'b1, v);
      chk("R9", "addr1 read zero", v, 32'h0);
      idle(15);

      // R2: status lanes after core 2 resumed
      do_read(1'b0, v);
      chk("R2", "status lanes", v, 32'h0102_0101);

      idle(3);
      finish_run();
   end
endmodule